// File: doc/BRIEF.md
# Character I/O and Interrupt Controller

This block is the I/O instruction unit of a 16-bit accumulator machine. It holds one 8-bit input character with a "full" flag, one 8-bit output character with a "ready" flag, and a single interrupt-enable bit. The sequencer drives `exec` while it executes an I/O instruction and passes IR bits 11 down to 6 on `ir_sel`. Exactly one of these bits is set, and that bit selects one of six operations: read a character into the accumulator, write a character out, skip-if-input-full, skip-if-output-ready, enable interrupts, or disable interrupts. Characters move through the low byte of the accumulator.

A device connects on two valid/ready character ports. The input flag doubles as the inverse of `rx_ready`, and the output flag doubles as the inverse of `tx_valid`. When the interrupt enable is set and either flag is 1, `irq` is raised toward the sequencer. The sequencer's acknowledge clears the enable so that interrupts do not nest.

Three small state machines do the work. The receive channel has states RX_EMPTY and RX_FULL. It moves RX_EMPTY→RX_FULL when a character is accepted, and RX_FULL→RX_EMPTY on a read. The transmit channel has states TX_READY and TX_BUSY. It moves TX_READY→TX_BUSY on a write, and TX_BUSY→TX_READY when the device takes the character. The enable controller has states IE_OFF and IE_ON. It moves IE_OFF→IE_ON on enable, and IE_ON→IE_OFF on disable or on acknowledge.

Top module: `char_io_ctrl`

## Requirements
- R1: After reset, `rx_ready`=1, `tx_valid`=0, `tx_data`=0, `irq`=0, `skip`=0 and `ac_wr`=0.
- R2: A character offered with `rx_valid`=1 while `rx_ready`=1 is captured, and `rx_ready` is 0 from the next cycle. A character offered while `rx_ready`=0 is ignored and the held character is unchanged.
- R3: Read, `ir_sel[5]` (IR bit 11, code F800), with `exec`=1 drives `ac_wr`=1 and `ac_wr_data` = the held character in that cycle. It also clears the input flag, so `rx_ready`=1 from the next cycle.
- R4: Write, `ir_sel[4]` (code F400), with `exec`=1 while the output flag is 1 loads `ac_lo` into `tx_data`. `tx_valid` is 1 from the next cycle.
- R5: A write executed while `tx_valid`=1 is ignored, and `tx_data` keeps its value.
- R6: `tx_ready`=1 while `tx_valid`=1 sets the output flag, and `tx_valid` is 0 from the next cycle.
- R7: Skip-on-input, `ir_sel[3]` (code F200), with `exec`=1 gives `skip`=1 in that cycle exactly when the input flag is 1.
- R8: Skip-on-output, `ir_sel[2]` (code F100), with `exec`=1 gives `skip`=1 in that cycle exactly when the output flag is 1.
- R9: `ir_sel[1]` (code F080) with `exec`=1 sets the interrupt enable from the next cycle. `ir_sel[0]` (code F040) clears it from the next cycle.
- R10: `irq` = enable AND (input flag OR output flag).
- R11: `irq_ack`=1 clears the interrupt enable from the next cycle.
- R12: While `exec`=0, `ir_sel` has no effect: no `skip`, no `ac_wr`, and no change to the flags or the enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exec | input | 1 | I/O instruction execute strobe |
| ir_sel | input | 6 | IR[11:6], one-hot operation select |
| ac_lo | input | 8 | Accumulator low byte |
| ac_wr | output | 1 | Load accumulator low byte |
| ac_wr_data | output | 8 | Character for the accumulator |
| skip | output | 1 | Skip-next-instruction request |
| irq | output | 1 | Interrupt request to sequencer |
| irq_ack | input | 1 | Sequencer entered the interrupt cycle |
| rx_valid | input | 1 | Device offers an input character |
| rx_data | input | 8 | Input character |
| rx_ready | output | 1 | Input register empty |
| tx_valid | output | 1 | Output character pending |
| tx_data | output | 8 | Output character |
| tx_ready | input | 1 | Device takes the pending character |

## Verification
The assertions assume that `ir_sel` is one-hot whenever `exec` is high. They also assume that `irq_ack` only arrives while `irq` is high, and that `rx_data` is meaningful only while `rx_valid` is high. The directed stimulus keeps to these rules: every instruction drives a single select bit for one cycle, and the acknowledge is issued only after the bench has seen `irq` high. Inputs change on the falling edge, so handshakes and instructions never overlap in a way the sequencer could not produce.

// File: rtl/cio_pkg.sv
package cio_pkg;
    localparam int CHAR_W  = 8;
    localparam int SEL_W   = 6;
    localparam int SEL_INP = 5;
    localparam int SEL_OUT = 4;
    localparam int SEL_SKI = 3;
    localparam int SEL_SKO = 2;
    localparam int SEL_ION = 1;
    localparam int SEL_IOF = 0;

    typedef enum logic { RX_EMPTY, RX_FULL } rx_state_t;
    typedef enum logic { TX_READY, TX_BUSY } tx_state_t;
    typedef enum logic { IE_OFF,   IE_ON   } ie_state_t;
endpackage

// File: rtl/cio_rx_chan.sv
module cio_rx_chan
    import cio_pkg::*;
#(
    parameter int W = CHAR_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         rx_valid,
    input  logic [W-1:0] rx_data,
    input  logic         do_read,
    output logic         rx_ready,
    output logic         in_flag,
    output logic [W-1:0] in_char
);
    rx_state_t state_q, state_d;
    logic      take;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RX_EMPTY;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        take    = 1'b0;
        unique case (state_q)
            RX_EMPTY: if (rx_valid) begin
                          state_d = RX_FULL;
                          take    = 1'b1;
                      end
            RX_FULL:  if (do_read) state_d = RX_EMPTY;
            default:  state_d = RX_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)    in_char <= '0;
        else if (take) in_char <= rx_data;
    end

    assign in_flag  = (state_q == RX_FULL);
    assign rx_ready = ~in_flag;

    AST_RX_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid && rx_ready |=> !rx_ready && in_char == $past(rx_data)); // R2
    AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_ready && !do_read |=> !rx_ready && $stable(in_char)); // R2
    AST_INP_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        do_read && !rx_ready |=> rx_ready); // R3
endmodule

// File: rtl/cio_tx_chan.sv
module cio_tx_chan
    import cio_pkg::*;
#(
    parameter int W = CHAR_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         do_write,
    input  logic [W-1:0] wr_char,
    input  logic         tx_ready,
    output logic         tx_valid,
    output logic         out_flag,
    output logic [W-1:0] tx_data
);
    tx_state_t state_q, state_d;
    logic      load;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= TX_READY;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        load    = 1'b0;
        unique case (state_q)
            TX_READY: if (do_write) begin
                          state_d = TX_BUSY;
                          load    = 1'b1;
                      end
            TX_BUSY:  if (tx_ready) state_d = TX_READY;
            default:  state_d = TX_READY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)    tx_data <= '0;
        else if (load) tx_data <= wr_char;
    end

    assign tx_valid = (state_q == TX_BUSY);
    assign out_flag = ~tx_valid;

    AST_OUT_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        do_write && !tx_valid |=> tx_valid && tx_data == $past(wr_char)); // R4
    AST_OUT_PENDING_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |=> $stable(tx_data)); // R5
    AST_TX_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && tx_ready |=> !tx_valid); // R6
endmodule

// File: rtl/cio_ien_ctrl.sv
module cio_ien_ctrl
    import cio_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic do_on,
    input  logic do_off,
    input  logic ack,
    output logic ien
);
    ie_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= IE_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IE_OFF:  if (do_on) state_d = IE_ON;
            IE_ON:   if (do_off || ack) state_d = IE_OFF;
            default: state_d = IE_OFF;
        endcase
    end

    assign ien = (state_q == IE_ON);

    AST_ION_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        do_on && !ack && !do_off |=> ien); // R9
    AST_IOF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        do_off |=> !ien); // R9
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ien); // R11
endmodule

// File: rtl/char_io_ctrl.sv
module char_io_ctrl
    import cio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              exec,
    input  logic [SEL_W-1:0]  ir_sel,
    input  logic [CHAR_W-1:0] ac_lo,
    output logic              ac_wr,
    output logic [CHAR_W-1:0] ac_wr_data,
    output logic              skip,
    output logic              irq,
    input  logic              irq_ack,
    input  logic              rx_valid,
    input  logic [CHAR_W-1:0] rx_data,
    output logic              rx_ready,
    output logic              tx_valid,
    output logic [CHAR_W-1:0] tx_data,
    input  logic              tx_ready
);
    logic [SEL_W-1:0] op;
    logic             in_flag, out_flag, ien;

    assign op = exec ? ir_sel : '0;

    cio_rx_chan #(.W(CHAR_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
        .do_read(op[SEL_INP]), .rx_ready(rx_ready), .in_flag(in_flag),
        .in_char(ac_wr_data)
    );

    cio_tx_chan #(.W(CHAR_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .do_write(op[SEL_OUT]), .wr_char(ac_lo),
        .tx_ready(tx_ready), .tx_valid(tx_valid), .out_flag(out_flag),
        .tx_data(tx_data)
    );

    cio_ien_ctrl u_ien (
        .clk(clk), .rst_n(rst_n), .do_on(op[SEL_ION]), .do_off(op[SEL_IOF]),
        .ack(irq_ack), .ien(ien)
    );

    assign ac_wr = op[SEL_INP];
    assign skip  = (op[SEL_SKI] & in_flag) | (op[SEL_SKO] & out_flag);
    assign irq   = ien & (in_flag | out_flag);

    AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        exec |-> $onehot0(ir_sel)); // R12
    AST_NO_EXEC_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !exec |-> !skip && !ac_wr); // R12
    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> rx_ready == 1'b0 || tx_valid == 1'b0); // R10
    AST_SKI_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        exec && ir_sel[SEL_SKI] && !rx_ready |-> skip); // R7
    AST_SKO_READY: assert property (@(posedge clk) disable iff (!rst_n)
        exec && ir_sel[SEL_SKO] && !tx_valid |-> skip); // R8
endmodule

// File: tb/char_io_ctrl_bench.sv
module char_io_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       exec = 1'b0;
    logic [5:0] ir_sel = '0;
    logic [7:0] ac_lo = '0;
    logic       ac_wr, skip, irq, rx_ready, tx_valid;
    logic [7:0] ac_wr_data, tx_data;
    logic       irq_ack = 1'b0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_data = '0;
    logic       tx_ready = 1'b0;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    localparam logic [5:0] OP_INP = 6'b100000;
    localparam logic [5:0] OP_OUT = 6'b010000;
    localparam logic [5:0] OP_SKI = 6'b001000;
    localparam logic [5:0] OP_SKO = 6'b000100;
    localparam logic [5:0] OP_ION = 6'b000010;
    localparam logic [5:0] OP_IOF = 6'b000001;

    always #2 clk = ~clk;

    char_io_ctrl u_char_io_ctrl (
        .clk(clk), .rst_n(rst_n), .exec(exec), .ir_sel(ir_sel), .ac_lo(ac_lo),
        .ac_wr(ac_wr), .ac_wr_data(ac_wr_data), .skip(skip), .irq(irq),
        .irq_ack(irq_ack), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_ready(rx_ready), .tx_valid(tx_valid), .tx_data(tx_data),
        .tx_ready(tx_ready)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // drive an instruction for one cycle; combinational results checked by caller at #1
    task automatic op_start(input logic [5:0] sel);
        @(negedge clk);
        exec = 1'b1; ir_sel = sel;
        #1;
    endtask

    task automatic op_end();
        @(negedge clk);
        exec = 1'b0; ir_sel = '0;
        #1;
    endtask

    task automatic deliver(input logic [7:0] c);
        @(negedge clk);
        rx_valid = 1'b1; rx_data = c;
        @(negedge clk);
        rx_valid = 1'b0; rx_data = '0;
        #1;
    endtask

    task automatic t_reset();
        chk("R1 rx_ready", rx_ready, 1);
        chk("R1 tx_valid", tx_valid, 0);
        chk("R1 tx_data", tx_data, 0);
        chk("R1 irq", irq, 0);
        chk("R1 skip", skip, 0);
        chk("R1 ac_wr", ac_wr, 0);
    endtask

    task automatic t_input();
        op_start(OP_SKI);
        chk("R7 skip empty", skip, 0);
        op_end();
        deliver(8'hA5);
        chk("R2 rx_ready after capture", rx_ready, 0);
        deliver(8'h3C);
        chk("R2 still full", rx_ready, 0);
        op_start(OP_SKI);
        chk("R7 skip full", skip, 1);
        op_end();
        op_start(OP_INP);
        chk("R3 ac_wr", ac_wr, 1);
        chk("R2 R3 ac_wr_data kept first char", ac_wr_data, 8'hA5);
        op_end();
        chk("R3 rx_ready after read", rx_ready, 1);
        chk("R3 ac_wr idle", ac_wr, 0);
        deliver(8'h3C);
        op_start(OP_INP);
        chk("R3 second char", ac_wr_data, 8'h3C);
        op_end();
    endtask

    task automatic t_output();
        op_start(OP_SKO);
        chk("R8 skip ready", skip, 1);
        op_end();
        ac_lo = 8'h5A;
        op_start(OP_OUT);
        op_end();
        chk("R4 tx_valid", tx_valid, 1);
        chk("R4 tx_data", tx_data, 8'h5A);
        op_start(OP_SKO);
        chk("R8 skip busy", skip, 0);
        op_end();
        ac_lo = 8'hFF;
        op_start(OP_OUT);
        op_end();
        chk("R5 tx_data held", tx_data, 8'h5A);
        chk("R5 tx_valid held", tx_valid, 1);
        @(negedge clk); tx_ready = 1'b1;
        @(negedge clk); tx_ready = 1'b0; #1;
        chk("R6 tx_valid dropped", tx_valid, 0);
        op_start(OP_SKO);
        chk("R8 skip after done", skip, 1);
        op_end();
    endtask

    task automatic t_irq();
        chk("R10 irq disabled", irq, 0);
        op_start(OP_ION);
        chk("R9 not yet", irq, 0);
        op_end();
        chk("R9 R10 irq enabled out flag", irq, 1);
        op_start(OP_IOF);
        op_end();
        chk("R9 irq after disable", irq, 0);
        op_start(OP_ION);
        op_end();
        ac_lo = 8'h11;
        op_start(OP_OUT);
        op_end();
        chk("R10 no flags", irq, 0);
        deliver(8'h77);
        chk("R10 input flag", irq, 1);
        @(negedge clk); irq_ack = 1'b1;
        @(negedge clk); irq_ack = 1'b0; #1;
        chk("R11 ack clears", irq, 0);
        @(negedge clk); tx_ready = 1'b1;
        @(negedge clk); tx_ready = 1'b0; #1;
        chk("R11 stays off", irq, 0);
        op_start(OP_INP);
        op_end();
    endtask

    task automatic t_no_exec();
        @(negedge clk); ir_sel = OP_ION; #1;
        chk("R12 no skip", skip, 0);
        @(negedge clk); ir_sel = OP_INP; #1;
        chk("R12 no ac_wr", ac_wr, 0);
        @(negedge clk); ir_sel = OP_OUT; ac_lo = 8'h99;
        @(negedge clk); ir_sel = OP_SKO; #1;
        chk("R12 skip sko", skip, 0);
        @(negedge clk); ir_sel = '0; #1;
        chk("R12 irq unchanged", irq, 0);
        chk("R12 tx_valid unchanged", tx_valid, 0);
        chk("R12 tx_data unchanged", tx_data, 8'h11);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset();
        t_input();
        t_output();
        t_irq();
        t_no_exec();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule